// File: doc/BRIEF.md
# DRAM Bank Row-Buffer Command Sequencer

This block drives the command stream for a single DRAM bank inside a memory controller. It keeps a model of the bank's row buffer: whether it is empty, and if a row is open, which one. Each accepted read or write request gives a row and a column. The block works out whether that request hits the open row, finds the bank empty, or conflicts with a different open row. It then issues the matching sequence of precharge, activate and column commands, one per cycle at most.

A static parameter chooses the row-buffer policy. Under the open policy the row stays open after every access. Under the closed policy the bank precharges right after each column command. The exception is when the requester raises `keep_row` to say that its next queued request wants the same row. In that case the row stays open and that next access becomes a hit.

Four per-bank minimum gaps are module parameters, and each is held by its own down-counter: activate to column, precharge to activate, activate to activate, and write to read.

Top module: `bank_rowbuf_seq`

## Requirements
- R1: After reset `req_ready` is 1, `cmd_code` is 0 (no command) and `acc_kind` is 0. The row buffer is empty, so the first request is classified as an empty-bank access.
- R2: A request accepted while the row buffer is empty is reported with `acc_kind`=2. It is followed by an activate (`cmd_code`=1) carrying the request row, then by its column command. A read uses code 2 and a write uses code 3.
- R3: A request to the row that is currently open is reported with `acc_kind`=3'd1 and gets exactly one command, the column command. No activate and no precharge are issued for it.
- R4: A request to a row other than the open one is reported with `acc_kind`=3. It gets a precharge (`cmd_code`=4), then an activate of the new row, then its column command.
- R5: With the closed policy (`OPEN_ROW`=0), a precharge is issued the cycle after every column command unless `keep_row` is 1 in the cycle the column command is issued. In that case the row stays open. With the open policy, `keep_row` has no effect.
- R6: Two activates are at least `T_RC` cycles apart.
- R7: A read is issued no sooner than `T_WTR` cycles after the last write.
- R8: A column command comes at least `T_RCD` cycles after the last activate. An activate comes at least `T_RP` cycles after the last precharge.
- R9: `req_ready` is 0 in every cycle in which a command is issued, and from acceptance until the sequence for that request has ended. It is 1 again once the bank is idle.
- R10: The first command of a sequence is issued in the cycle after acceptance, or later if a gap in R6 to R8 requires it. Every later command comes at the earliest cycle that the previous command and those gaps allow.
- R11: The column command carries the request column on `cmd_col`. The activate carries the request row on `cmd_row`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | The bank is idle and takes the offered request |
| req_write | input | 1 | 1 for a write request, 0 for a read request |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| keep_row | input | 1 | A queued request targets the current row (used by the closed policy only) |
| cmd_code | output | 3 | 0 none, 1 activate, 2 read, 3 write, 4 precharge |
| cmd_row | output | ROW_W | Row for an activate (the open row for a precharge) |
| cmd_col | output | COL_W | Column for a read or write |
| acc_kind | output | 2 | In the acceptance cycle: 1 hit, 2 empty bank, 3 conflict; 0 otherwise |

## Verification
`acc_kind` is combinational, so the bench reads it in the acceptance cycle itself, just after it drives the request. Commands depend only on registered state, the gap counters and `keep_row`. The first command can therefore appear no earlier than the cycle after the accepting edge. The bench keeps its own row-buffer model and its own record of the last activate, precharge and write. From these it computes the exact cycle each command is due: one cycle after the previous command, pushed later by any gap still running. All outputs are logged at the falling edge and compared against those computed cycles, codes, rows and columns, for both policies, in a sweep that mixes hits, conflicts, empty-bank accesses and back-to-back write-read pairs.

// File: rtl/bank_seq_pkg.sv
package bank_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } bank_cmd_e;

    typedef enum logic [1:0] {
        ACC_NONE     = 2'd0,
        ACC_HIT      = 2'd1,
        ACC_EMPTY    = 2'd2,
        ACC_CONFLICT = 2'd3
    } acc_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ACT,
        ST_COL,
        ST_CPRE
    } seq_state_e;

    // Indices into the gap-timer vector.
    localparam int TMR_RCD = 0;
    localparam int TMR_RP  = 1;
    localparam int TMR_RC  = 2;
    localparam int TMR_WTR = 3;
    localparam int TMR_N   = 4;

endpackage

// File: rtl/bank_gap_timer.sv
module bank_gap_timer #(
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int W = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [W-1:0] LOAD = W'(GAP - 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    AST_TMR_HOLDS_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> ((GAP == 1) || !done)); // R8

endmodule

// File: rtl/bank_row_match.sv
module bank_row_match
    import bank_seq_pkg::*;
#(
    parameter int ROW_W = 4
) (
    input  logic             is_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] want_row,
    output acc_kind_e        kind
);
    always_comb begin
        if (!is_open)
            kind = ACC_EMPTY;
        else if (open_row == want_row)
            kind = ACC_HIT;
        else
            kind = ACC_CONFLICT;
    end
endmodule

// File: rtl/bank_rowbuf_seq.sv
module bank_rowbuf_seq
    import bank_seq_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 3,
    parameter int T_RCD    = 2,
    parameter int T_RP     = 2,
    parameter int T_RC     = 7,
    parameter int T_WTR    = 4,
    parameter int OPEN_ROW = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_write,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic             keep_row,
    output logic [2:0]       cmd_code,
    output logic [ROW_W-1:0] cmd_row,
    output logic [COL_W-1:0] cmd_col,
    output logic [1:0]       acc_kind
);
    localparam int GAPS [TMR_N] = '{T_RCD, T_RP, T_RC, T_WTR};

    typedef struct packed {
        seq_state_e       st;
        logic             open;
        logic [ROW_W-1:0] row;
        logic [ROW_W-1:0] p_row;
        logic [COL_W-1:0] p_col;
        logic             p_wr;
    } bank_regs_t;

    bank_regs_t r_d, r_q;
    bank_cmd_e  cmd;
    acc_kind_e  match_kind;
    logic [TMR_N-1:0] tmr_start, tmr_done;
    logic close_after;
    logic accept;

    bank_row_match #(.ROW_W(ROW_W)) u_match (
        .is_open (r_q.open),
        .open_row(r_q.row),
        .want_row(req_row),
        .kind    (match_kind)
    );

    for (genvar g = 0; g < TMR_N; g++) begin : g_tmr
        bank_gap_timer #(.GAP(GAPS[g])) u_tmr (
            .clk  (clk),
            .rst_n(rst_n),
            .start(tmr_start[g]),
            .done (tmr_done[g])
        );
    end

    // Policy choice: whether the row is closed after a column command.
    if (OPEN_ROW != 0) begin : g_open_policy
        assign close_after = keep_row & 1'b0;
    end else begin : g_closed_policy
        assign close_after = !keep_row;
    end

    always_comb begin
        r_d       = r_q;
        cmd       = CMD_NOP;
        tmr_start = '0;
        req_ready = (r_q.st == ST_IDLE);
        accept    = req_valid && req_ready;
        acc_kind  = accept ? match_kind : ACC_NONE;
        cmd_row   = r_q.p_row;
        cmd_col   = r_q.p_col;

        unique case (r_q.st)
            ST_IDLE: begin
                if (accept) begin
                    r_d.p_row = req_row;
                    r_d.p_col = req_col;
                    r_d.p_wr  = req_write;
                    unique case (match_kind)
                        ACC_HIT:   r_d.st = ST_COL;
                        ACC_EMPTY: r_d.st = ST_ACT;
                        default:   r_d.st = ST_PRE;
                    endcase
                end
            end
            ST_PRE: begin
                cmd                = CMD_PRE;
                cmd_row            = r_q.row;
                r_d.open           = 1'b0;
                tmr_start[TMR_RP]  = 1'b1;
                r_d.st             = ST_ACT;
            end
            ST_ACT: begin
                if (tmr_done[TMR_RP] && tmr_done[TMR_RC]) begin
                    cmd                = CMD_ACT;
                    r_d.open           = 1'b1;
                    r_d.row            = r_q.p_row;
                    tmr_start[TMR_RCD] = 1'b1;
                    tmr_start[TMR_RC]  = 1'b1;
                    r_d.st             = ST_COL;
                end
            end
            ST_COL: begin
                if (tmr_done[TMR_RCD] && (r_q.p_wr || tmr_done[TMR_WTR])) begin
                    cmd                = r_q.p_wr ? CMD_WR : CMD_RD;
                    tmr_start[TMR_WTR] = r_q.p_wr;
                    r_d.st             = close_after ? ST_CPRE : ST_IDLE;
                end
            end
            ST_CPRE: begin
                cmd               = CMD_PRE;
                cmd_row           = r_q.row;
                r_d.open          = 1'b0;
                tmr_start[TMR_RP] = 1'b1;
                r_d.st            = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.open  <= 1'b0;
            r_q.row   <= '0;
            r_q.p_row <= '0;
            r_q.p_col <= '0;
            r_q.p_wr  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cmd_code = cmd;

    // ---------------------------------------------------------------
    // Checker: cycles elapsed since the last command of each kind.
    // ---------------------------------------------------------------
    localparam int GM1  = (T_RC > T_WTR) ? T_RC : T_WTR;
    localparam int GM2  = (T_RCD > T_RP) ? T_RCD : T_RP;
    localparam int GMAX = (GM1 > GM2) ? GM1 : GM2;
    localparam int SW   = $clog2(GMAX + 1) + 1;
    localparam logic [SW-1:0] SAT = SW'(GMAX);

    logic [SW-1:0] since_act, since_pre, since_wr;
    logic is_col;
    assign is_col = (cmd == CMD_RD) || (cmd == CMD_WR);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= SAT;
            since_pre <= SAT;
            since_wr  <= SAT;
        end else begin
            if (cmd == CMD_ACT)       since_act <= SW'(1);
            else if (since_act < SAT) since_act <= since_act + 1'b1;
            if (cmd == CMD_PRE)       since_pre <= SW'(1);
            else if (since_pre < SAT) since_pre <= since_pre + 1'b1;
            if (cmd == CMD_WR)        since_wr  <= SW'(1);
            else if (since_wr < SAT)  since_wr  <= since_wr + 1'b1;
        end
    end

    AST_ACT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_act >= SW'(T_RC))); // R6
    AST_RD_AFTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RD) |-> (since_wr >= SW'(T_WTR))); // R7
    AST_COL_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act >= SW'(T_RCD))); // R8
    AST_ACT_AFTER_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ACT) |-> (since_pre >= SW'(T_RP))); // R8
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> !req_ready); // R9
    AST_HIT_NO_ROWCMD: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_HIT) |=> (cmd != CMD_ACT && cmd != CMD_PRE)); // R3
    AST_CONFLICT_PRE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == ACC_CONFLICT) |=> (cmd == CMD_PRE)); // R4

endmodule

// File: tb/bank_rowbuf_seq_bench.sv
`timescale 1ns/1ps
module bank_rowbuf_seq_bench;
    localparam int ROW_W = 4;
    localparam int COL_W = 3;
    localparam int T_RCD = 2;
    localparam int T_RP  = 2;
    localparam int T_RC  = 7;
    localparam int T_WTR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [1:0]       rv;
    logic             rq_wr, rq_keep;
    logic [ROW_W-1:0] rq_row;
    logic [COL_W-1:0] rq_col;
    logic             rdy  [2];
    logic [2:0]       cmd  [2];
    logic [ROW_W-1:0] crow [2];
    logic [COL_W-1:0] ccol [2];
    logic [1:0]       kind [2];

    // Instance 0: open policy; instance 1: closed policy.
    for (genvar g = 0; g < 2; g++) begin : g_dut
        bank_rowbuf_seq #(
            .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD), .T_RP(T_RP),
            .T_RC(T_RC), .T_WTR(T_WTR), .OPEN_ROW((g == 0) ? 1 : 0)
        ) u_bank_rowbuf_seq (
            .clk(clk), .rst_n(rst_n), .req_valid(rv[g]), .req_ready(rdy[g]),
            .req_write(rq_wr), .req_row(rq_row), .req_col(rq_col),
            .keep_row(rq_keep), .cmd_code(cmd[g]), .cmd_row(crow[g]),
            .cmd_col(ccol[g]), .acc_kind(kind[g])
        );
    end

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int checks = 0;
    int failures = 0;
    bit done_flag = 0;

    // Command log filled at falling edges.
    bit mon_on = 0;
    int sel = 0;
    int nlog = 0;
    bit rdy_bad = 0;
    int lg_code [8];
    int lg_t    [8];
    int lg_row  [8];
    int lg_col  [8];

    always @(negedge clk) begin
        if (mon_on && cmd[sel] != 3'd0) begin
            if (nlog < 8) begin
                lg_code[nlog] = int'(cmd[sel]);
                lg_t[nlog]    = cyc;
                lg_row[nlog]  = int'(crow[sel]);
                lg_col[nlog]  = int'(ccol[sel]);
            end
            nlog = nlog + 1;
            if (rdy[sel]) rdy_bad = 1;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Bench model of each bank.
    bit bopen [2];
    int brow  [2];
    int lact  [2];
    int lpre  [2];
    int lwr   [2];
    int ract  [2];
    int rpre  [2];
    int rwr   [2];

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    task automatic do_req(input int s, input int row, input int col, input bit w, input bit k);
        int ek;
        int en;
        int ec [5];
        int et [5];
        int t;
        int t0;
        string ktag;
        while (!rdy[s]) @(negedge clk);
        if (!bopen[s])         begin ek = 2; ktag = "R2"; end
        else if (brow[s] == row) begin ek = 1; ktag = "R3"; end
        else                   begin ek = 3; ktag = "R4"; end
        sel = s;
        rq_row = ROW_W'(row);
        rq_col = COL_W'(col);
        rq_wr = w;
        rq_keep = k;
        rv[s] = 1'b1;
        #1;
        check(kind[s] == 2'(ek), {ktag, " acc_kind"}, int'(kind[s]), ek);
        t0 = cyc;
        nlog = 0;
        rdy_bad = 0;
        mon_on = 1;
        @(negedge clk);
        rv[s] = 1'b0;
        while (!rdy[s]) @(negedge clk);
        mon_on = 0;

        // Expected sequence.
        en = 0;
        if (ek == 3) begin ec[en] = 4; en++; end
        if (ek != 1) begin ec[en] = 1; en++; end
        ec[en] = w ? 3 : 2; en++;
        if (s == 1 && !k) begin ec[en] = 4; en++; end
        // Expected cycles (R10).
        t = t0;
        for (int i = 0; i < en; i++) begin
            int e;
            e = t + 1;
            if (ec[i] == 1) begin
                e = imax(e, imax(lact[s] + T_RC, lpre[s] + T_RP));
                lact[s] = e;
            end else if (ec[i] == 2) begin
                e = imax(e, imax(lact[s] + T_RCD, lwr[s] + T_WTR));
            end else if (ec[i] == 3) begin
                e = imax(e, lact[s] + T_RCD);
                lwr[s] = e;
            end else begin
                lpre[s] = e;
            end
            et[i] = e;
            t = e;
        end

        check(nlog == en, "R2/R3/R4/R5 command count", nlog, en);
        check(!rdy_bad, "R9 ready low while issuing", int'(rdy_bad), 0);
        for (int i = 0; i < en && i < nlog && i < 8; i++) begin
            check(lg_code[i] == ec[i], "R2/R4/R5 command code", lg_code[i], ec[i]);
            check(lg_t[i] == et[i], "R10 command cycle", lg_t[i] - t0, et[i] - t0);
            if (lg_code[i] == 1) begin
                check(lg_row[i] == row, "R11 activate row", lg_row[i], row);
                check(lg_t[i] - ract[s] >= T_RC, "R6 activate spacing", lg_t[i] - ract[s], T_RC);
                check(lg_t[i] - rpre[s] >= T_RP, "R8 precharge to activate", lg_t[i] - rpre[s], T_RP);
                ract[s] = lg_t[i];
            end
            if (lg_code[i] == 2 || lg_code[i] == 3) begin
                check(lg_col[i] == col, "R11 column", lg_col[i], col);
                check(lg_t[i] - ract[s] >= T_RCD, "R8 activate to column", lg_t[i] - ract[s], T_RCD);
            end
            if (lg_code[i] == 2)
                check(lg_t[i] - rwr[s] >= T_WTR, "R7 write to read", lg_t[i] - rwr[s], T_WTR);
            if (lg_code[i] == 3) rwr[s] = lg_t[i];
            if (lg_code[i] == 4) rpre[s] = lg_t[i];
        end

        // Model update.
        bopen[s] = 1;
        brow[s] = row;
        if (s == 1 && !k) bopen[s] = 0;
    endtask

    initial begin
        rv = '0; rq_wr = 0; rq_keep = 0; rq_row = '0; rq_col = '0;
        for (int s = 0; s < 2; s++) begin
            bopen[s] = 0; brow[s] = 0;
            lact[s] = -1000; lpre[s] = -1000; lwr[s] = -1000;
            ract[s] = -1000; rpre[s] = -1000; rwr[s] = -1000;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        for (int s = 0; s < 2; s++) begin
            check(rdy[s] == 1'b1, "R1 ready after reset", int'(rdy[s]), 1);
            check(cmd[s] == 3'd0, "R1 no command after reset", int'(cmd[s]), 0);
            check(kind[s] == 2'd0, "R1 acc_kind idle", int'(kind[s]), 0);
        end
        for (int s = 0; s < 2; s++) begin
            for (int i = 0; i < 48; i++) begin
                int row;
                row = ((i / 2) * 3 + (i / 7)) % 4;
                do_req(s, row, i % 8, (i % 3) == 0, (i % 4) != 3);
            end
            // Read right after write to the same row, keep flag set (R5, R7).
            do_req(s, 2, 1, 1'b1, 1'b1);
            do_req(s, 2, 5, 1'b0, 1'b1);
            do_req(s, 3, 6, 1'b0, 1'b0);
            do_req(s, 3, 7, 1'b1, 1'b0);
        end
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule